// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table held in memory. A caller presents a request made of the virtual address, a write flag and a user-mode flag. The walker then issues one or two word reads through a single-outstanding memory port. A first-level entry either maps a 1 MB section directly or points to a 256-entry second-level table. A second-level entry maps a 64 KB large page or a 4 KB small page.

Each translation is checked against a 16-domain access control word. Permission is checked per sub-page: a page has four 2-bit permission fields, one for each quarter of the page. Two static permission modifiers, a system-override bit and a read-only-everywhere bit, are plain configuration pins. They, the table base and the access control word must be held stable while a walk is in flight.

The block returns exactly one result per accepted request. A result is either the physical address with its cacheable and bufferable attributes, or a 4-bit fault code.

Three ports use valid/ready and have these back-pressure rules:
- The request port accepts one request at a time.
- The memory request is held, unchanged, until it is taken. Memory responses are never back-pressured.
- The result is held, unchanged, until the consumer asserts ready.

Top module: `tt_walker`

## Requirements
- R1: `req_ready` is high only when no walk is in progress and no result is waiting. A request is taken on a cycle where `req_valid` and `req_ready` are both high. No further request is taken until the result has been consumed.
- R2: The first read goes to `{ttb[31:14], va[31:20], 2'b00}`. The low 14 bits of the table base are ignored.
- R3: If first-level type bits [1:0] are 00 or 11, the result is fault code 4'h5 (section translation fault). No second read is issued.
- R4: First-level type 10 is a section. It completes after exactly one read with physical address `{d1[31:20], va[19:0]}`. Cacheable comes from descriptor bit 3 and bufferable from bit 2.
- R5: First-level type 01 points to a second-level table. The second read goes to `{d1[31:10], va[19:12], 2'b00}`.
- R6: If second-level type bits [1:0] are 00 or 11, the result is fault code 4'h7 (page translation fault).
- R7: Second-level type 01 is a large page with physical address `{d2[31:16], va[15:0]}`; its sub-page is selected by va[15:14]. Type 10 is a small page with physical address `{d2[31:12], va[11:0]}`; its sub-page is selected by va[11:10]. Sub-page k uses permission bits d2[5+2k:4+2k]. Cacheable and bufferable come from bits 3 and 2.
- R8: The domain number is first-level bits [8:5], and its 2-bit control field is `dacr[2d+1:2d]`. A field of 00 or 10 gives a domain fault: 4'h9 for a section, 4'hB for a page. A field of 11 skips the permission check. A field of 01 applies it.
- R9: The permission check uses a section's bits [11:10] or a page's selected sub-page field:
  - 3 allows everything.
  - 2 allows supervisor read/write and user reads.
  - 1 allows supervisor access only.
  - 0 allows only reads, and only when `sys_en` is set in supervisor mode or `rom_en` is set in either mode.

  A denied access gives 4'hD for a section or 4'hF for a page.
- R10: `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`. The result outputs stay stable while `res_valid` is high and `res_ready` is low.
- R11: On a fault, `res_fault` is 1, the physical address is zero and both attributes are 0. On success, `res_fault` is 0 and the code is 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| ttb | input | 32 | Translation table base (16 KB aligned) |
| dacr | input | 32 | Domain access control, 2 bits per domain |
| sys_en | input | 1 | System permission modifier |
| rom_en | input | 1 | ROM permission modifier |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Word address of the descriptor |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_pa | output | 32 | Physical address (zero on fault) |
| res_cacheable | output | 1 | Cacheable attribute |
| res_bufferable | output | 1 | Bufferable attribute |
| res_fault | output | 1 | Result is a fault |
| res_code | output | 4 | Fault code, 4'h0 when no fault |

## Verification
The table geometry is fixed by package constants: 4096 first-level entries, 256 second-level entries, 16 domains and 4 sub-pages. The bench builds the walker with exactly these values, so every field position it checks is the real one.

Its memory model can be switched between an always-ready port and one that accepts only every third cycle. This reaches the hold rule on the memory request, with either table level outstanding.

Holding the result consumer off for several cycles reaches the stability and no-accept rules. Running the permission check through all four encodings, both modes, both access types and both modifier bits covers the whole access table.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int VA_W      = 32;
  localparam int DOM_CNT   = 16;
  localparam int DOM_W     = $clog2(DOM_CNT);
  localparam int SUB_CNT   = 4;
  localparam int SUB_W     = $clog2(SUB_CNT);
  localparam int L1_IDX_W  = 12;
  localparam int L2_IDX_W  = 8;
  localparam int PT_BASE_W = VA_W - L2_IDX_W - 2;
  localparam int CODE_W    = 4;

  localparam logic [1:0] L1_PT  = 2'b01;
  localparam logic [1:0] L1_SEC = 2'b10;
  localparam logic [1:0] L2_LRG = 2'b01;
  localparam logic [1:0] L2_SML = 2'b10;

  localparam logic [CODE_W-1:0] FC_NONE    = 4'h0;
  localparam logic [CODE_W-1:0] FC_XLT_SEC = 4'h5;
  localparam logic [CODE_W-1:0] FC_XLT_PG  = 4'h7;
  localparam logic [CODE_W-1:0] FC_DOM_SEC = 4'h9;
  localparam logic [CODE_W-1:0] FC_DOM_PG  = 4'hB;
  localparam logic [CODE_W-1:0] FC_PRM_SEC = 4'hD;
  localparam logic [CODE_W-1:0] FC_PRM_PG  = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/walk_compose.sv
module walk_compose
  import walk_pkg::*;
(
  input  logic [VA_W-1:0]      ttb,
  input  logic [VA_W-1:0]      va,
  input  logic [VA_W-1:0]      desc,
  input  logic [PT_BASE_W-1:0] pt_base,
  output logic [VA_W-1:0]      l1_addr,
  output logic [VA_W-1:0]      l2_addr,
  output logic [VA_W-1:0]      sec_pa,
  output logic [VA_W-1:0]      pg_pa,
  output logic [1:0]           sec_ap,
  output logic [1:0]           pg_ap
);
  logic [1:0]       ap_field [SUB_CNT];
  logic [SUB_W-1:0] sub_sel;
  logic             is_large;
  logic             unused_bits;

  assign unused_bits = ^{ttb[VA_W-L1_IDX_W-7:0], desc[3:2]};

  assign l1_addr = {ttb[VA_W-1:VA_W-L1_IDX_W-6], va[VA_W-1:VA_W-L1_IDX_W], 2'b00};
  assign l2_addr = {pt_base, va[19:12], 2'b00};
  assign sec_pa  = {desc[31:20], va[19:0]};
  assign sec_ap  = desc[11:10];

  assign is_large = (desc[1:0] == L2_LRG);
  assign pg_pa    = is_large ? {desc[31:16], va[15:0]} : {desc[31:12], va[11:0]};
  assign sub_sel  = is_large ? va[15:14] : va[11:10];

  for (genvar g = 0; g < SUB_CNT; g++) begin : g_sub
    assign ap_field[g] = desc[4+2*g +: 2];
  end

  assign pg_ap = ap_field[sub_sel];
endmodule

// File: rtl/walk_access.sv
module walk_access
  import walk_pkg::*;
(
  input  logic [2*DOM_CNT-1:0] dacr,
  input  logic [DOM_W-1:0]     dom,
  input  logic [1:0]           ap,
  input  logic                 wr,
  input  logic                 usr,
  input  logic                 sys_en,
  input  logic                 rom_en,
  output logic                 dom_fault,
  output logic                 perm_fault
);
  logic [1:0] dctl;
  logic       manager;
  logic       allowed;

  assign dctl      = dacr[{dom, 1'b0} +: 2];
  assign dom_fault = ~dctl[0];
  assign manager   = (dctl == 2'b11);

  always_comb begin
    unique case (ap)
      2'd0:    allowed = ~wr & ((sys_en & ~usr) | rom_en);
      2'd1:    allowed = ~usr;
      2'd2:    allowed = ~usr | ~wr;
      default: allowed = 1'b1;
    endcase
  end

  assign perm_fault = ~manager & ~allowed;
endmodule

// File: rtl/tt_walker.sv
module tt_walker
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] ttb,
  input  logic [31:0] dacr,
  input  logic        sys_en,
  input  logic        rom_en,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_pa,
  output logic        res_cacheable,
  output logic        res_bufferable,
  output logic        res_fault,
  output logic [3:0]  res_code
);
  walk_st_e             st;
  logic [VA_W-1:0]      va_q;
  logic                 wr_q, usr_q;
  logic [PT_BASE_W-1:0] pt_base_q;
  logic [DOM_W-1:0]     dom_q;

  logic [VA_W-1:0]      l1_addr, l2_addr, sec_pa, pg_pa;
  logic [1:0]           sec_ap, pg_ap;
  logic [DOM_W-1:0]     chk_dom;
  logic [1:0]           chk_ap;
  logic                 dom_f, perm_f;

  logic                 fin, go_l2;
  logic [CODE_W-1:0]    n_code;
  logic [VA_W-1:0]      n_pa;
  logic                 n_c, n_b;

  walk_compose u_comp (
    .ttb     (ttb),
    .va      (va_q),
    .desc    (mem_rsp_data),
    .pt_base (pt_base_q),
    .l1_addr (l1_addr),
    .l2_addr (l2_addr),
    .sec_pa  (sec_pa),
    .pg_pa   (pg_pa),
    .sec_ap  (sec_ap),
    .pg_ap   (pg_ap)
  );

  assign chk_dom = (st == ST_L2_WAIT) ? dom_q : mem_rsp_data[8:5];
  assign chk_ap  = (st == ST_L2_WAIT) ? pg_ap : sec_ap;

  walk_access u_acc (
    .dacr       (dacr),
    .dom        (chk_dom),
    .ap         (chk_ap),
    .wr         (wr_q),
    .usr        (usr_q),
    .sys_en     (sys_en),
    .rom_en     (rom_en),
    .dom_fault  (dom_f),
    .perm_fault (perm_f)
  );

  always_comb begin
    fin    = 1'b0;
    go_l2  = 1'b0;
    n_code = FC_NONE;
    n_pa   = '0;
    n_c    = 1'b0;
    n_b    = 1'b0;
    if (mem_rsp_valid) begin
      if (st == ST_L1_WAIT) begin
        if (mem_rsp_data[1:0] == L1_PT) begin
          go_l2 = 1'b1;
        end else if (mem_rsp_data[1:0] == L1_SEC) begin
          fin = 1'b1;
          if (dom_f)       n_code = FC_DOM_SEC;
          else if (perm_f) n_code = FC_PRM_SEC;
          else begin
            n_pa = sec_pa;
            n_c  = mem_rsp_data[3];
            n_b  = mem_rsp_data[2];
          end
        end else begin
          fin    = 1'b1;
          n_code = FC_XLT_SEC;
        end
      end else if (st == ST_L2_WAIT) begin
        fin = 1'b1;
        if (mem_rsp_data[1:0] != L2_LRG && mem_rsp_data[1:0] != L2_SML)
          n_code = FC_XLT_PG;
        else if (dom_f)  n_code = FC_DOM_PG;
        else if (perm_f) n_code = FC_PRM_PG;
        else begin
          n_pa = pg_pa;
          n_c  = mem_rsp_data[3];
          n_b  = mem_rsp_data[2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= ST_IDLE;
      va_q           <= '0;
      wr_q           <= 1'b0;
      usr_q          <= 1'b0;
      pt_base_q      <= '0;
      dom_q          <= '0;
      res_pa         <= '0;
      res_cacheable  <= 1'b0;
      res_bufferable <= 1'b0;
      res_fault      <= 1'b0;
      res_code       <= FC_NONE;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          va_q  <= req_va;
          wr_q  <= req_write;
          usr_q <= req_user;
          st    <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready) st <= ST_L1_WAIT;
        ST_L1_WAIT: if (go_l2) begin
          pt_base_q <= mem_rsp_data[31:10];
          dom_q     <= mem_rsp_data[8:5];
          st        <= ST_L2_REQ;
        end
        ST_L2_REQ: if (mem_req_ready) st <= ST_L2_WAIT;
        ST_L2_WAIT: ;
        ST_DONE: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (fin) begin
        res_pa         <= n_pa;
        res_cacheable  <= n_c;
        res_bufferable <= n_b;
        res_fault      <= (n_code != FC_NONE);
        res_code       <= n_code;
        st             <= ST_DONE;
      end
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
  assign mem_req_addr  = (st == ST_L2_REQ) ? l2_addr : l1_addr;
  assign res_valid     = (st == ST_DONE);
endmodule

// File: rtl/walk_checker.sv
module walk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_va,
  input logic [31:0] ttb,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_pa,
  input logic        res_fault,
  input logic [3:0]  res_code
);
  logic [31:0] va_c;
  logic [1:0]  rd_c;
  logic        unused_bits;

  assign unused_bits = ^ttb[13:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_c <= '0;
      rd_c <= '0;
    end else if (req_valid && req_ready) begin
      va_c <= req_va;
      rd_c <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      rd_c <= rd_c + 2'd1;
    end
  end

  a_r1_no_accept_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  a_r2_first_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && rd_c == 2'd0) |-> mem_req_addr == {ttb[31:14], va_c[31:20], 2'b00});

  a_r3_section_fault_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 4'h5) |-> rd_c == 2'd1);

  a_r4_section_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault && rd_c == 2'd1) |-> res_pa[19:0] == va_c[19:0]);

  a_r7_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault && rd_c == 2'd2) |-> res_pa[11:0] == va_c[11:0]);

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_code) && $stable(res_fault)));

  a_r11_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fault == (res_code != 4'h0)));
endmodule

bind tt_walker walk_checker u_walk_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_va        (req_va),
  .ttb           (ttb),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_pa        (res_pa),
  .res_fault     (res_fault),
  .res_code      (res_code)
);

// File: tb/sim_tt_walker.sv
`timescale 1ns/1ps
module sim_tt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready;
  logic [31:0] ttb = 32'h0010_0000 | 32'h0000_1234;
  logic [31:0] dacr = '0;
  logic        sys_en = 1'b0, rom_en = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid, res_ready = 1'b0;
  logic [31:0] res_pa;
  logic        res_cacheable, res_bufferable, res_fault;
  logic [3:0]  res_code;

  always #2.5 clk = ~clk;

  tt_walker u0 (.*);

  logic [31:0] mem [logic [31:0]];
  int          rd_cnt = 0;
  int          cyc = 0;
  bit          stall_mode = 1'b0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc           <= cyc + 1;
    mem_req_ready <= !stall_mode || (cyc % 3 == 2);
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      rd_cnt        <= rd_cnt + 1;
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_rd(mem_req_addr);
    end
  end

  int checks = 0, fails = 0;
  logic [31:0] g_pa;
  logic        g_c, g_b, g_f;
  logic [3:0]  g_code;
  int          g_reads;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] l1_loc(input logic [31:0] va);
    return {ttb[31:14], va[31:20], 2'b00};
  endfunction

  function automatic logic [31:0] dom_set(input logic [31:0] base, input int d, input logic [1:0] v);
    logic [31:0] r = base;
    r[2*d +: 2] = v;
    return r;
  endfunction

  task automatic walk(input logic [31:0] va, input logic wr, input logic usr, input int hold);
    int base, guard;
    @(negedge clk);
    req_va = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    base = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!res_valid && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    g_pa = res_pa; g_c = res_cacheable; g_b = res_bufferable; g_f = res_fault; g_code = res_code;
    g_reads = rd_cnt - base;
    if (!res_valid) chk("R1", "result never valid", 32'd0, 32'd1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R10", "held valid", {31'd0, res_valid}, 32'd1);
      chk("R10", "held pa", res_pa, g_pa);
      chk("R1", "busy ready", {31'd0, req_ready}, 32'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1", "reset res_valid", {31'd0, res_valid}, 32'd0);
    chk("R10", "reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_section;
    dacr = dom_set(32'h0, 2, 2'b01);
    mem[l1_loc(32'h1234_5678)] = 32'hABC0_0000 | (32'd3 << 10) | (32'd2 << 5) | 32'hC | 32'h2;
    walk(32'h1234_5678, 1'b1, 1'b1, 0);
    chk("R4", "section pa", g_pa, 32'hABC4_5678);
    chk("R4", "section C/B", {30'd0, g_c, g_b}, 32'd3);
    chk("R4", "section reads", g_reads, 32'd1);
    chk("R11", "section code", {28'd0, g_code}, 32'h0);
  endtask

  task automatic t_l1_fault;
    mem[l1_loc(32'h2000_0000)] = 32'hFFF0_0000;
    walk(32'h2000_0000, 1'b0, 1'b0, 0);
    chk("R3", "type00 code", {28'd0, g_code}, 32'h5);
    chk("R3", "type00 reads", g_reads, 32'd1);
    chk("R11", "fault pa zero", g_pa, 32'h0);
    mem[l1_loc(32'h2010_0000)] = 32'hFFF0_0FFF;
    walk(32'h2010_0000, 1'b0, 1'b0, 0);
    chk("R3", "type11 code", {28'd0, g_code}, 32'h5);
    chk("R11", "fault flag", {31'd0, g_f}, 32'd1);
  endtask

  task automatic t_small;
    dacr = dom_set(32'h0, 1, 2'b01);
    mem[l1_loc(32'h3000_5C00)] = 32'h0080_0400 | (32'd1 << 5) | 32'h1;
    mem[32'h0080_0414] = 32'h7777_7000 | (32'd3 << 10) | 32'h4 | 32'h2;
    walk(32'h3000_5C00, 1'b1, 1'b1, 0);
    chk("R5", "small reads", g_reads, 32'd2);
    chk("R7", "small pa", g_pa, 32'h7777_7C00);
    chk("R7", "small C/B", {30'd0, g_c, g_b}, 32'd1);
    walk(32'h3000_5400, 1'b0, 1'b1, 0);
    chk("R9", "sub-page 1 ap0 user read", {28'd0, g_code}, 32'hF);
    chk("R11", "fault C/B zero", {30'd0, g_c, g_b}, 32'd0);
  endtask

  task automatic t_large;
    dacr = dom_set(32'h0, 1, 2'b01);
    mem[l1_loc(32'h4012_C123)] = 32'h0090_0000 | (32'd1 << 5) | 32'h1;
    mem[32'h0090_00B0] = 32'h5555_0000 | (32'd2 << 10) | 32'h8 | 32'h1;
    walk(32'h4012_C123, 1'b1, 1'b0, 0);
    chk("R7", "large pa", g_pa, 32'h5555_C123);
    chk("R7", "large C/B", {30'd0, g_c, g_b}, 32'd2);
    chk("R5", "large reads", g_reads, 32'd2);
    walk(32'h4012_C123, 1'b1, 1'b1, 0);
    chk("R9", "large user write ap2", {28'd0, g_code}, 32'hF);
  endtask

  task automatic t_l2_invalid;
    mem[l1_loc(32'h4500_0000)] = 32'h00A0_0000 | (32'd1 << 5) | 32'h1;
    walk(32'h4500_0000, 1'b0, 1'b0, 0);
    chk("R6", "l2 invalid code", {28'd0, g_code}, 32'h7);
    chk("R6", "l2 invalid reads", g_reads, 32'd2);
    mem[32'h00A0_0000] = 32'h1234_5003;
    walk(32'h4500_0000, 1'b0, 1'b0, 0);
    chk("R6", "l2 type11 code", {28'd0, g_code}, 32'h7);
  endtask

  task automatic t_domain;
    mem[l1_loc(32'h5000_0000)] = 32'h0B00_0000 | (32'd0 << 10) | (32'd4 << 5) | 32'h2;
    dacr = dom_set(32'hFFFF_FFFF, 4, 2'b00);
    walk(32'h5000_0000, 1'b0, 1'b0, 0);
    chk("R8", "section dom 00", {28'd0, g_code}, 32'h9);
    dacr = dom_set(32'hFFFF_FFFF, 4, 2'b10);
    walk(32'h5000_0000, 1'b0, 1'b0, 0);
    chk("R8", "section dom 10", {28'd0, g_code}, 32'h9);
    dacr = dom_set(32'h0, 4, 2'b11);
    walk(32'h5000_0000, 1'b1, 1'b1, 0);
    chk("R8", "manager bypass", {28'd0, g_code}, 32'h0);
    chk("R8", "manager pa", g_pa, 32'h0B00_0000);
    dacr = dom_set(32'hFFFF_FFFF, 1, 2'b00);
    walk(32'h3000_5C00, 1'b0, 1'b0, 0);
    chk("R8", "page dom 00", {28'd0, g_code}, 32'hB);
  endtask

  function automatic bit perm_ok(input int ap, input bit wr, input bit usr, input bit s, input bit r);
    case (ap)
      0: return !wr && ((s && !usr) || r);
      1: return !usr;
      2: return !usr || !wr;
      default: return 1'b1;
    endcase
  endfunction

  task automatic t_perm_matrix;
    dacr = dom_set(32'h0, 1, 2'b01);
    for (int ap = 0; ap < 4; ap++) begin
      mem[l1_loc(32'h6000_0000)] = 32'h0A00_0000 | (ap << 10) | (32'd1 << 5) | 32'h2;
      for (int m = 0; m < 16; m++) begin
        sys_en = m[2]; rom_en = m[3];
        walk(32'h6000_0ABC, m[0], m[1], 0);
        chk("R9", $sformatf("ap%0d m%0d", ap, m), {28'd0, g_code},
            perm_ok(ap, m[0], m[1], m[2], m[3]) ? 32'h0 : 32'hD);
      end
    end
    sys_en = 1'b0; rom_en = 1'b0;
  endtask

  task automatic t_backpressure;
    stall_mode = 1'b1;
    dacr = dom_set(32'h0, 1, 2'b01);
    walk(32'h3000_5C00, 1'b0, 1'b0, 5);
    chk("R10", "stalled page pa", g_pa, 32'h7777_7C00);
    dacr = dom_set(32'h0, 2, 2'b01);
    walk(32'h1234_5678, 1'b0, 1'b0, 3);
    chk("R10", "stalled section pa", g_pa, 32'hABC4_5678);
    stall_mode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_section;
    t_l1_fault;
    t_small;
    t_large;
    t_l2_invalid;
    t_domain;
    t_perm_matrix;
    t_backpressure;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule